// File: doc/BRIEF.md
# Cascaded Two-Level Interrupt Controller

This block gathers level-sensitive interrupt requests from three 8-bit groups and turns them into two CPU interrupt lines. Two local groups each own an 8-bit mask and drive one interrupt output. A third, mapped group of eight requests is not wired to the CPU directly. It is filtered by two separate 8-bit mapped masks. The OR of each filtered result replaces one fixed bit of a local group: the first mapped mask feeds local group 0 bit 7, and the second feeds local group 1 bit 3. A mapped source therefore passes through two mask levels before it can reach the CPU.

Software sees a small byte-wide register window with a 4-bit address. The window holds three read-only status bytes and four read/write mask bytes. The status bytes show the live request lines, with the folded mapped bits in place of the local input bits they replace. Numbering software places on the sources: levels 0–7 are local group 0, levels 8–15 are local group 1, levels 16–23 are mapped sources under mapped mask 0, and levels 24–31 are mapped sources under mapped mask 1. Mapped mask 1 sits four byte addresses above mapped mask 0, so software can pick either with one base address plus (selector × 4).

Top module: `irq_cascade_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, all four mask bytes are zero, both interrupt outputs are low and the read data is zero. No interrupt can assert until software sets a mask bit.
- R2: The local mask bytes are at address 0x1 (group 0) and 0x3 (group 1). A read of a mask address returns exactly the last byte written there.
- R3: `irqLocal0` is a register. After each clock edge it equals the OR over the bits of (local-0 status AND local-0 mask), with both sampled at that edge. It therefore follows a request or mask change one cycle later and drops when the source drops or is masked.
- R4: `irqLocal1` follows the same rule for local-1 status and the local-1 mask.
- R5: Local-0 status bit 7 is the OR of (mapped requests AND mapped mask 0). Input `reqLocal0[7]` has no effect on status or interrupt.
- R6: Local-1 status bit 3 is the OR of (mapped requests AND mapped mask 1). Input `reqLocal1[3]` has no effect on status or interrupt.
- R7: Mapped mask 0 is at address 0x5 and mapped mask 1 is at address 0x9, which is 4 above. Writing one of them leaves the other unchanged.
- R8: The status addresses are 0x0 (local 0), 0x2 (local 1) and 0x4 (mapped). They are read-only: a write there changes no mask and no status. A read of any address that is not listed returns 0x00.
- R9: Read data is registered. When `regRdEn` is high at a clock edge, `regRdData` shows the addressed byte after that edge and holds it until the next read. A read and a write to the same mask address in the same cycle return the value held before the write.
- R10: A read of the mapped status address returns the raw mapped requests, not masked by either mapped mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqLocal0 | input | 8 | Level requests of local group 0 (bit 7 replaced by mapped fold) |
| reqLocal1 | input | 8 | Level requests of local group 1 (bit 3 replaced by mapped fold) |
| reqMapped | input | 8 | Level requests of the mapped group |
| regAddr | input | 4 | Register byte address |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 8 | Write data |
| regRdEn | input | 1 | Read strobe |
| regRdData | output | 8 | Registered read data |
| irqLocal0 | output | 1 | CPU interrupt from local group 0 |
| irqLocal1 | output | 1 | CPU interrupt from local group 1 |

## Verification
Two kinds of event can fall in the same clock cycle. In the first, a mask write lands on the same edge as a request change. The interrupt register must then combine the new request level with the mask value from before the write, and the new mask must show on the output only one cycle later. In the second, a read and a write hit the same mask address together, and the read must return the old byte. The bench provokes both by driving requests, write strobe and read strobe in a single cycle. A scoreboard, fed from a model of the requirements, judges the interrupt outputs and the read data on the cycle after that edge.

// File: rtl/irq_cascade_pkg.sv
package irq_cascade_pkg;

  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] ADDR_L0_STAT   = 4'h0;
  localparam logic [ADDR_W-1:0] ADDR_L0_MASK   = 4'h1;
  localparam logic [ADDR_W-1:0] ADDR_L1_STAT   = 4'h2;
  localparam logic [ADDR_W-1:0] ADDR_L1_MASK   = 4'h3;
  localparam logic [ADDR_W-1:0] ADDR_MAP_STAT  = 4'h4;
  localparam logic [ADDR_W-1:0] ADDR_MAP_MASK0 = 4'h5;
  localparam int                MAP_STRIDE     = 4;
  localparam logic [ADDR_W-1:0] ADDR_MAP_MASK1 = ADDR_MAP_MASK0 + ADDR_W'(MAP_STRIDE);

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_L0_STAT,
    SEL_L0_MASK,
    SEL_L1_STAT,
    SEL_L1_MASK,
    SEL_MAP_STAT,
    SEL_MAP_MASK0,
    SEL_MAP_MASK1
  } rdSel_e;

  typedef struct packed {
    logic       wrL0Mask;
    logic       wrL1Mask;
    logic [1:0] wrMapMask;
    logic       rdCapture;
    rdSel_e     rdSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/irq_cascade_decode.sv
module irq_cascade_decode
  import irq_cascade_pkg::*;
(
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  output ctrlStrobe_t       strobe
);

  rdSel_e sel;

  always_comb begin
    unique case (regAddr)
      ADDR_L0_STAT:   sel = SEL_L0_STAT;
      ADDR_L0_MASK:   sel = SEL_L0_MASK;
      ADDR_L1_STAT:   sel = SEL_L1_STAT;
      ADDR_L1_MASK:   sel = SEL_L1_MASK;
      ADDR_MAP_STAT:  sel = SEL_MAP_STAT;
      ADDR_MAP_MASK0: sel = SEL_MAP_MASK0;
      ADDR_MAP_MASK1: sel = SEL_MAP_MASK1;
      default:        sel = SEL_NONE;
    endcase
  end

  always_comb begin
    strobe              = '0;
    strobe.rdSel        = sel;
    strobe.rdCapture    = regRdEn;
    strobe.wrL0Mask     = regWrEn && (sel == SEL_L0_MASK);
    strobe.wrL1Mask     = regWrEn && (sel == SEL_L1_MASK);
    strobe.wrMapMask[0] = regWrEn && (sel == SEL_MAP_MASK0);
    strobe.wrMapMask[1] = regWrEn && (sel == SEL_MAP_MASK1);
  end

endmodule

// File: rtl/irq_cascade_datapath.sv
module irq_cascade_datapath
  import irq_cascade_pkg::*;
#(
  parameter int GRP_W       = 8,
  parameter int L0_FOLD_BIT = 7,
  parameter int L1_FOLD_BIT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrlStrobe_t      strobe,
  input  logic [GRP_W-1:0] reqLocal0,
  input  logic [GRP_W-1:0] reqLocal1,
  input  logic [GRP_W-1:0] reqMapped,
  input  logic [GRP_W-1:0] wrData,
  output logic [GRP_W-1:0] rdData,
  output logic             irqLocal0,
  output logic             irqLocal1
);

  localparam int MAP_CNT = 2;

  logic [GRP_W-1:0]              maskL0Q;
  logic [GRP_W-1:0]              maskL1Q;
  logic [MAP_CNT-1:0][GRP_W-1:0] mapMaskQ;
  logic [MAP_CNT-1:0]            mapHit;
  logic [GRP_W-1:0]              statL0;
  logic [GRP_W-1:0]              statL1;
  logic [GRP_W-1:0]              rdNext;

  // Mapped masks and their folded hits.
  for (genvar g = 0; g < MAP_CNT; g++) begin : gMap
    always_ff @(posedge clk) begin
      if (!rst_n)                 mapMaskQ[g] <= '0;
      else if (strobe.wrMapMask[g]) mapMaskQ[g] <= wrData;
    end
    assign mapHit[g] = |(reqMapped & mapMaskQ[g]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      maskL0Q <= '0;
      maskL1Q <= '0;
    end else begin
      if (strobe.wrL0Mask) maskL0Q <= wrData;
      if (strobe.wrL1Mask) maskL1Q <= wrData;
    end
  end

  // Local status with the cascade bits folded in.
  always_comb begin
    statL0              = reqLocal0;
    statL0[L0_FOLD_BIT] = mapHit[0];
    statL1              = reqLocal1;
    statL1[L1_FOLD_BIT] = mapHit[1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irqLocal0 <= 1'b0;
      irqLocal1 <= 1'b0;
    end else begin
      irqLocal0 <= |(statL0 & maskL0Q);
      irqLocal1 <= |(statL1 & maskL1Q);
    end
  end

  always_comb begin
    unique case (strobe.rdSel)
      SEL_L0_STAT:   rdNext = statL0;
      SEL_L0_MASK:   rdNext = maskL0Q;
      SEL_L1_STAT:   rdNext = statL1;
      SEL_L1_MASK:   rdNext = maskL1Q;
      SEL_MAP_STAT:  rdNext = reqMapped;
      SEL_MAP_MASK0: rdNext = mapMaskQ[0];
      SEL_MAP_MASK1: rdNext = mapMaskQ[1];
      default:       rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                rdData <= '0;
    else if (strobe.rdCapture) rdData <= rdNext;
  end

endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl
  import irq_cascade_pkg::*;
#(
  parameter int GRP_W       = 8,
  parameter int L0_FOLD_BIT = 7,
  parameter int L1_FOLD_BIT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [GRP_W-1:0]  reqLocal0,
  input  logic [GRP_W-1:0]  reqLocal1,
  input  logic [GRP_W-1:0]  reqMapped,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [GRP_W-1:0]  regWrData,
  input  logic              regRdEn,
  output logic [GRP_W-1:0]  regRdData,
  output logic              irqLocal0,
  output logic              irqLocal1
);

  ctrlStrobe_t strobe;

  irq_cascade_decode u_decode (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .strobe  (strobe)
  );

  irq_cascade_datapath #(
    .GRP_W       (GRP_W),
    .L0_FOLD_BIT (L0_FOLD_BIT),
    .L1_FOLD_BIT (L1_FOLD_BIT)
  ) u_datapath (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .reqLocal0 (reqLocal0),
    .reqLocal1 (reqLocal1),
    .reqMapped (reqMapped),
    .wrData    (regWrData),
    .rdData    (regRdData),
    .irqLocal0 (irqLocal0),
    .irqLocal1 (irqLocal1)
  );

endmodule

// File: rtl/irq_cascade_chk.sv
module irq_cascade_chk
  import irq_cascade_pkg::*;
#(
  parameter int GRP_W       = 8,
  parameter int L0_FOLD_BIT = 7,
  parameter int L1_FOLD_BIT = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [GRP_W-1:0]  reqLocal0,
  input logic [GRP_W-1:0]  reqLocal1,
  input logic [GRP_W-1:0]  reqMapped,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWrEn,
  input logic [GRP_W-1:0]  regWrData,
  input logic              regRdEn,
  input logic [GRP_W-1:0]  regRdData,
  input logic              irqLocal0,
  input logic              irqLocal1
);

  logic [GRP_W-1:0] shL0, shL1, shM0, shM1;
  logic [GRP_W-1:0] expSt0, expSt1;
  logic             expIrq0Q, expIrq1Q;
  logic             unmappedAddr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shL0 <= '0; shL1 <= '0; shM0 <= '0; shM1 <= '0;
    end else if (regWrEn) begin
      if (regAddr == ADDR_L0_MASK)   shL0 <= regWrData;
      if (regAddr == ADDR_L1_MASK)   shL1 <= regWrData;
      if (regAddr == ADDR_MAP_MASK0) shM0 <= regWrData;
      if (regAddr == ADDR_MAP_MASK1) shM1 <= regWrData;
    end
  end

  always_comb begin
    expSt0 = reqLocal0;
    expSt0[L0_FOLD_BIT] = (reqMapped & shM0) != '0;
    expSt1 = reqLocal1;
    expSt1[L1_FOLD_BIT] = (reqMapped & shM1) != '0;
    unmappedAddr = !(regAddr inside {ADDR_L0_STAT, ADDR_L0_MASK, ADDR_L1_STAT,
                                     ADDR_L1_MASK, ADDR_MAP_STAT, ADDR_MAP_MASK0,
                                     ADDR_MAP_MASK1});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      expIrq0Q <= 1'b0;
      expIrq1Q <= 1'b0;
    end else begin
      expIrq0Q <= (expSt0 & shL0) != '0;
      expIrq1Q <= (expSt1 & shL1) != '0;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!irqLocal0 && !irqLocal1 && regRdData == '0));

  assert_irq0_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irqLocal0 == expIrq0Q);

  assert_irq1_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irqLocal1 == expIrq1Q);

  assert_mask_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (regRdEn && regAddr == ADDR_L0_MASK) |=> regRdData == $past(shL0));

  assert_map1_readback_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (regRdEn && regAddr == ADDR_MAP_MASK1) |=> regRdData == $past(shM1));

  assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (regRdEn && unmappedAddr) |=> regRdData == '0);

  assert_map_stat_raw_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (regRdEn && regAddr == ADDR_MAP_STAT) |=> regRdData == $past(reqMapped));

endmodule

bind irq_cascade_ctrl irq_cascade_chk #(
  .GRP_W       (GRP_W),
  .L0_FOLD_BIT (L0_FOLD_BIT),
  .L1_FOLD_BIT (L1_FOLD_BIT)
) u_chk (.*);

// File: tb/irq_cascade_ctrl_tb.sv
module irq_cascade_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] reqLocal0 = '0, reqLocal1 = '0, reqMapped = '0;
  logic [3:0] regAddr = '0;
  logic       regWrEn = 1'b0, regRdEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       irqLocal0, irqLocal1;

  always #2.5 clk = ~clk;

  irq_cascade_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .reqLocal0(reqLocal0), .reqLocal1(reqLocal1), .reqMapped(reqMapped),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdEn(regRdEn), .regRdData(regRdData),
    .irqLocal0(irqLocal0), .irqLocal1(irqLocal1)
  );

  typedef struct {
    int         due;
    int         kind;   // 0 read data, 1 irqLocal0, 2 irqLocal1
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // requirement model of the mask bytes
  logic [7:0] m0 = '0, m1 = '0, mm0 = '0, mm1 = '0;

  always @(posedge clk) cyc++;

  function automatic logic [7:0] st0(input logic [7:0] r0, input logic [7:0] rm);
    logic [7:0] s = r0;
    s[7] = |(rm & mm0);
    return s;
  endfunction

  function automatic logic [7:0] st1(input logic [7:0] r1, input logic [7:0] rm);
    logic [7:0] s = r1;
    s[3] = |(rm & mm1);
    return s;
  endfunction

  function automatic logic [7:0] modelRead(input logic [3:0] a, input logic [7:0] r0,
                                           input logic [7:0] r1, input logic [7:0] rm);
    case (a)
      4'h0: return st0(r0, rm);
      4'h1: return m0;
      4'h2: return st1(r1, rm);
      4'h3: return m1;
      4'h4: return rm;
      4'h5: return mm0;
      4'h9: return mm1;
      default: return 8'h00;
    endcase
  endfunction

  // driver: one cycle of stimulus, expectations pushed to the scoreboard
  task automatic tick(input logic [7:0] r0, input logic [7:0] r1, input logic [7:0] rm,
                      input logic wr, input logic rd, input logic [3:0] a,
                      input logic [7:0] wd, input string rdTag, input string irqTag);
    item_t it;
    @(negedge clk);
    reqLocal0 = r0; reqLocal1 = r1; reqMapped = rm;
    regWrEn = wr; regRdEn = rd; regAddr = a; regWrData = wd;
    if (rd) begin
      it.due = cyc + 1; it.kind = 0; it.exp = modelRead(a, r0, r1, rm); it.tag = rdTag;
      q.push_back(it);
    end
    it.due = cyc + 1; it.kind = 1; it.exp = {7'd0, |(st0(r0, rm) & m0)}; it.tag = irqTag;
    q.push_back(it);
    it.due = cyc + 1; it.kind = 2; it.exp = {7'd0, |(st1(r1, rm) & m1)}; it.tag = irqTag;
    q.push_back(it);
    if (wr) begin
      case (a)
        4'h1: m0 = wd;
        4'h3: m1 = wd;
        4'h5: mm0 = wd;
        4'h9: mm1 = wd;
        default: ;
      endcase
    end
  endtask

  // monitor: pops due items and compares
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      item_t it;
      logic [7:0] got;
      it = q.pop_front();
      case (it.kind)
        0: got = regRdData;
        1: got = {7'd0, irqLocal0};
        default: got = {7'd0, irqLocal1};
      endcase
      checks++;
      if (got !== it.exp) begin
        errors++;
        $display("FAIL %s kind=%0d actual=%02h expected=%02h at cycle %0d",
                 it.tag, it.kind, got, it.exp, cyc);
      end
    end
  end

  task automatic wrReg(input logic [7:0] r0, input logic [7:0] r1, input logic [7:0] rm,
                       input logic [3:0] a, input logic [7:0] d, input string tag);
    tick(r0, r1, rm, 1'b1, 1'b0, a, d, tag, tag);
  endtask

  task automatic rdReg(input logic [7:0] r0, input logic [7:0] r1, input logic [7:0] rm,
                       input logic [3:0] a, input string tag);
    tick(r0, r1, rm, 1'b0, 1'b1, a, 8'h00, tag, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (irqLocal0 !== 1'b0 || irqLocal1 !== 1'b0 || regRdData !== 8'h00) begin
      errors++;
      $display("FAIL R1 reset outputs actual=%b%b/%02h expected=00/00",
               irqLocal0, irqLocal1, regRdData);
    end
    rst_n = 1'b1;

    // R1: masks zero, all requests high yet no interrupt
    rdReg(8'hFF, 8'hFF, 8'hFF, 4'h1, "R1");
    rdReg(8'hFF, 8'hFF, 8'hFF, 4'h3, "R1");
    rdReg(8'hFF, 8'hFF, 8'hFF, 4'h5, "R1");
    rdReg(8'hFF, 8'hFF, 8'hFF, 4'h9, "R1");

    // R2/R3: local-0 mask and interrupt path
    wrReg(8'h00, 8'h00, 8'h00, 4'h1, 8'h0F, "R2");
    rdReg(8'h00, 8'h00, 8'h00, 4'h1, "R2");
    tick(8'h01, 8'h00, 8'h00, 0, 0, 4'h0, 8'h00, "R3", "R3");
    tick(8'h01, 8'h00, 8'h00, 0, 0, 4'h0, 8'h00, "R3", "R3");
    tick(8'h10, 8'h00, 8'h00, 0, 0, 4'h0, 8'h00, "R3", "R3");
    tick(8'h08, 8'h00, 8'h00, 0, 0, 4'h0, 8'h00, "R3", "R3");
    tick(8'h00, 8'h00, 8'h00, 0, 0, 4'h0, 8'h00, "R3", "R3");

    // R4: local-1 mask and interrupt path
    wrReg(8'h00, 8'h00, 8'h00, 4'h3, 8'hF0, "R2");
    rdReg(8'h00, 8'h00, 8'h00, 4'h3, "R2");
    tick(8'h00, 8'h10, 8'h00, 0, 0, 4'h0, 8'h00, "R4", "R4");
    tick(8'h00, 8'h01, 8'h00, 0, 0, 4'h0, 8'h00, "R4", "R4");
    tick(8'h00, 8'h80, 8'h00, 0, 0, 4'h0, 8'h00, "R4", "R4");
    tick(8'h00, 8'h00, 8'h00, 0, 0, 4'h0, 8'h00, "R4", "R4");

    // R5: raw bit 7 of local 0 has no effect; mapped fold drives it
    wrReg(8'h00, 8'h00, 8'h00, 4'h1, 8'h80, "R5");
    tick(8'h80, 8'h00, 8'h00, 0, 1, 4'h0, 8'h00, "R5", "R5");
    tick(8'h80, 8'h00, 8'h00, 0, 0, 4'h0, 8'h00, "R5", "R5");
    wrReg(8'h80, 8'h00, 8'h00, 4'h5, 8'h04, "R5");
    tick(8'h00, 8'h00, 8'h04, 0, 1, 4'h0, 8'h00, "R5", "R5");
    tick(8'h00, 8'h00, 8'h08, 0, 1, 4'h0, 8'h00, "R5", "R5");
    tick(8'h00, 8'h00, 8'h04, 0, 0, 4'h0, 8'h00, "R5", "R5");

    // R6/R7: second mapped mask at +4 feeds local-1 bit 3
    wrReg(8'h00, 8'h00, 8'h00, 4'h3, 8'h08, "R6");
    tick(8'h00, 8'h08, 8'h00, 0, 1, 4'h2, 8'h00, "R6", "R6");
    tick(8'h00, 8'h08, 8'h00, 0, 0, 4'h0, 8'h00, "R6", "R6");
    wrReg(8'h00, 8'h00, 8'h00, 4'h9, 8'h20, "R7");
    rdReg(8'h00, 8'h00, 8'h00, 4'h9, "R7");
    rdReg(8'h00, 8'h00, 8'h00, 4'h5, "R7");
    tick(8'h00, 8'h00, 8'h20, 0, 1, 4'h2, 8'h00, "R6", "R6");
    tick(8'h00, 8'h00, 8'h24, 0, 1, 4'h0, 8'h00, "R6", "R6");
    tick(8'h00, 8'h00, 8'h00, 0, 0, 4'h0, 8'h00, "R6", "R6");

    // R8: status writes ignored, unmapped reads zero
    wrReg(8'h00, 8'h00, 8'h00, 4'h0, 8'hFF, "R8");
    wrReg(8'h00, 8'h00, 8'h00, 4'h2, 8'hFF, "R8");
    wrReg(8'h00, 8'h00, 8'h00, 4'h4, 8'hFF, "R8");
    rdReg(8'h00, 8'h00, 8'h00, 4'h1, "R8");
    rdReg(8'h00, 8'h00, 8'h00, 4'h3, "R8");
    rdReg(8'h00, 8'h00, 8'h00, 4'h5, "R8");
    rdReg(8'h00, 8'h00, 8'h00, 4'h0, "R8");
    rdReg(8'h00, 8'h00, 8'h00, 4'hF, "R8");
    rdReg(8'h00, 8'h00, 8'h00, 4'h7, "R8");

    // R10: mapped status is raw, unmasked
    rdReg(8'h00, 8'h00, 8'hC3, 4'h4, "R10");
    rdReg(8'h00, 8'h00, 8'h5A, 4'h4, "R10");

    // R9: read and write of the same mask in one cycle, then read data holds
    tick(8'h00, 8'h00, 8'h00, 1, 1, 4'h1, 8'h3C, "R9", "R9");
    rdReg(8'h00, 8'h00, 8'h00, 4'h1, "R9");
    tick(8'h00, 8'h00, 8'h00, 0, 0, 4'h0, 8'h00, "R9", "R9");
    checks++;
    if (regRdData !== 8'h3C) begin
      errors++;
      $display("FAIL R9 read data hold actual=%02h expected=3c", regRdData);
    end

    // R3: request rises in the same cycle that a mask write disables it
    tick(8'h04, 8'h00, 8'h00, 1, 0, 4'h1, 8'h00, "R3", "R3");
    tick(8'h04, 8'h00, 8'h00, 0, 0, 4'h0, 8'h00, "R3", "R3");
    tick(8'h04, 8'h00, 8'h00, 1, 0, 4'h1, 8'h04, "R3", "R3");
    tick(8'h04, 8'h00, 8'h00, 0, 0, 4'h0, 8'h00, "R3", "R3");
    tick(8'h00, 8'h00, 8'h00, 0, 0, 4'h0, 8'h00, "R3", "R3");

    repeat (3) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule